// File: doc/BRIEF.md
# Dual-Mode Interrupt Pin Controller

This block owns one active-low, open-drain interrupt pin of a hub and decides what that pin means. In event mode the pin reports latched status events. Each status bit is set by a one-cycle event pulse. A bit counts toward the interrupt only when its enable bit is set. The pin stays pulled low until software clears the pending bits by writing ones to them. In link mode the pin instead follows the hub's USB state. It is pulled low while the hub is unconfigured, or configured but suspended. It is released only while the hub is configured and active.

Software reaches the block through a small register port. It has one address bus, a write strobe and a combinational read. Address 0 is the status register, which is cleared by writing 1 to a bit. Address 1 is the enable register. Address 2 is the control register: bit 0 selects the mode, where 0 is event and 1 is link. The pad itself sees a single output-enable: when it is 1 the pad drives 0, and when it is 0 the pad floats so a pull-up can take the line high. That enable comes from a flop, so every change appears one clock edge after the state that causes it.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset the status, enable and control registers read 0 and `irq_pull_low` is 0 (pin released).
- R2: An event pulse on `evt_i[i]` sets status bit i at that clock edge, and reading address 0 then shows it.
- R3: A write to address 0 clears every status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Address 1 reads back the last value written to it. Address 2 holds the mode in bit 0, where 0 is event mode and 1 is link mode. Its other bits read 0.
- R6: In event mode, `irq_pull_low` becomes 1 one edge after any bit of (status AND enable) is 1. It stays 1 while that condition holds, and it returns to 0 one edge after the condition is gone.
- R7: A status bit whose enable bit is 0 still latches events but never pulls the pin low.
- R8: Enabling a status bit that is already set pulls the pin low one edge after the write.
- R9: In link mode, `irq_pull_low` is 0 one edge after `hub_configured`=1 and `hub_suspended`=0 are sampled, and 1 one edge after any other combination is sampled.
- R10: Status bits keep latching events in link mode. After a return to event mode, pending enabled bits pull the pin low one edge after the mode write.
- R11: Address 3 reads 0, and writes to it change no register and do not change the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | STAT_W | One-cycle status event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | STAT_W | Register write data |
| reg_rdata | output | STAT_W | Register read data for `reg_addr` |
| hub_configured | input | 1 | Hub has been configured by the host |
| hub_suspended | input | 1 | Hub is in USB suspend |
| irq_pull_low | output | 1 | Open-drain enable: 1 drives the pin low, 0 releases it |

## Verification
The pin flop adds one edge of latency to every cause. A wrong status or enable bit therefore shows up on `irq_pull_low` at the next edge while event mode is active. In link mode it stays hidden until the mode returns to event mode, after which it shows one edge after the mode write. Read data exposes status, enable and mode combinationally in the same cycle. The bench checks read data and the pin after every edge, so a bad clear, a lost set-over-clear race or a stray write to the spare address is seen within one cycle of the register that holds it.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  typedef enum logic {
    PIN_MODE_EVENT = 1'b0,
    PIN_MODE_LINK  = 1'b1
  } pin_mode_e;

  // Hub is configured and running: the only state that releases the pin in link mode.
  function automatic logic link_running(input logic configured, input logic suspended);
    return configured & ~suspended;
  endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q;

  // Per bit: an event sets, a clear resets, and the event wins a tie.
  function automatic logic next_bit(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= next_bit(stat_q[i], evt_i[i], clr_i[i]);
    end

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> stat_q[i]);
    a_r3_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !evt_i[i]) |=> !stat_q[i]);
    a_r3_falls_only_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_q[i]) |-> $past(clr_i[i]));
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pin_pkg::*;
#(
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [STAT_W-1:0] clr_o,
  output logic [STAT_W-1:0] en_o,
  output pin_mode_e         mode_o,
  output logic [STAT_W-1:0] rdata_o
);
  logic [STAT_W-1:0] en_q;
  pin_mode_e         mode_q;
  logic              wr_status, wr_enable, wr_ctrl;

  assign wr_status = we_i && (addr_i == ADDR_STATUS);
  assign wr_enable = we_i && (addr_i == ADDR_ENABLE);
  assign wr_ctrl   = we_i && (addr_i == ADDR_CTRL);

  assign clr_o = wr_status ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= PIN_MODE_EVENT;
    end else begin
      if (wr_enable) en_q <= wdata_i;
      if (wr_ctrl)   mode_q <= pin_mode_e'(wdata_i[0]);
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_STATUS: rdata_o = stat_i;
      ADDR_ENABLE: rdata_o = en_q;
      ADDR_CTRL:   rdata_o = {{(STAT_W-1){1'b0}}, mode_q};
      default:     rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;

  a_r5_mode_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (mode_q == pin_mode_e'($past(wdata_i[0]))));
  a_r5_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> (en_q == $past(wdata_i)));
  a_r11_spare_addr_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == 2'd3) |=> ($stable(en_q) && $stable(mode_q)));
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import irq_pin_pkg::*;
#(
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] en_i,
  input  pin_mode_e         mode_i,
  input  logic              hub_cfg_i,
  input  logic              hub_susp_i,
  output logic              pull_low_o
);
  logic event_pending;
  logic link_low;
  logic pull_low_q;

  function automatic logic any_enabled(input logic [STAT_W-1:0] s, input logic [STAT_W-1:0] e);
    return |(s & e);
  endfunction

  assign event_pending = any_enabled(stat_i, en_i);
  assign link_low      = ~link_running(hub_cfg_i, hub_susp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_low_q <= 1'b0;
    else        pull_low_q <= (mode_i == PIN_MODE_LINK) ? link_low : event_pending;
  end

  assign pull_low_o = pull_low_q;

  a_r1_released_in_reset: assert property (@(posedge clk)
    !rst_n |-> !pull_low_q);
  a_r6_event_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PIN_MODE_EVENT && event_pending) |=> pull_low_q);
  a_r6_event_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PIN_MODE_EVENT && !event_pending) |=> !pull_low_q);
  a_r9_link_released: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PIN_MODE_LINK && hub_cfg_i && !hub_susp_i) |=> !pull_low_q);
  a_r9_link_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PIN_MODE_LINK && (!hub_cfg_i || hub_susp_i)) |=> pull_low_q);
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pin_pkg::*;
#(
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  input  logic              hub_configured,
  input  logic              hub_suspended,
  output logic              irq_pull_low
);
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] clear_mask;
  logic [STAT_W-1:0] enable;
  pin_mode_e         mode;

  irq_status_bank #(.STAT_W(STAT_W)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .clr_i  (clear_mask),
    .stat_o (status)
  );

  irq_cfg_regs #(.STAT_W(STAT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .stat_i  (status),
    .clr_o   (clear_mask),
    .en_o    (enable),
    .mode_o  (mode),
    .rdata_o (reg_rdata)
  );

  irq_pin_drive #(.STAT_W(STAT_W)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_i     (status),
    .en_i       (enable),
    .mode_i     (mode),
    .hub_cfg_i  (hub_configured),
    .hub_susp_i (hub_suspended),
    .pull_low_o (irq_pull_low)
  );
endmodule

// File: tb/irq_pin_ctrl_bench.sv
module irq_pin_ctrl_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] evt_i = '0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         hub_configured = 1'b0;
  logic         hub_suspended = 1'b0;
  logic         irq_pull_low;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_stat = '0;
  logic [W-1:0] m_en = '0;
  logic         m_mode = 1'b0;
  logic         m_pin = 1'b0;

  always #5 clk = ~clk;

  irq_pin_ctrl #(.STAT_W(W)) u_irq_pin_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_i          (evt_i),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .hub_configured (hub_configured),
    .hub_suspended  (hub_suspended),
    .irq_pull_low   (irq_pull_low)
  );

  function automatic logic [W-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_stat;
      2'd1:    return m_en;
      2'd2:    return {{(W-1){1'b0}}, m_mode};
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_pin(input logic mode, input logic [W-1:0] s,
                                   input logic [W-1:0] e, input logic c, input logic p);
    if (mode) return !(c && !p);
    return (s & e) != '0;
  endfunction

  task automatic check(input string tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, update the model with the rising edge, compare after it.
  task automatic step(input logic [W-1:0] ev, input logic we, input logic [1:0] a,
                      input logic [W-1:0] wd, input logic cfg, input logic sus, input string tag);
    logic [W-1:0] clr;
    logic         npin;
    @(negedge clk);
    evt_i = ev; reg_we = we; reg_addr = a; reg_wdata = wd;
    hub_configured = cfg; hub_suspended = sus;
    @(posedge clk);
    clr  = (we && a == 2'd0) ? wd : '0;
    npin = exp_pin(m_mode, m_stat, m_en, cfg, sus);
    m_stat = ev | (m_stat & ~clr);
    if (we && a == 2'd1) m_en = wd;
    if (we && a == 2'd2) m_mode = wd[0];
    m_pin = npin;
    #1;
    check(tag, "pin", {{(W-1){1'b0}}, irq_pull_low}, {{(W-1){1'b0}}, m_pin});
    check(tag, "rdata", reg_rdata, exp_read(a));
  endtask

  task automatic idle(input logic [1:0] a, input string tag);
    step('0, 1'b0, a, '0, hub_configured, hub_suspended, tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "pin in reset", {{(W-1){1'b0}}, irq_pull_low}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 3; a++) idle(a[1:0], "R1");

    // R2 and R7: event latches, but stays hidden while disabled.
    step(8'h08, 1'b0, 2'd0, '0, 1'b0, 1'b0, "R2");
    idle(2'd0, "R7");
    idle(2'd0, "R7");
    // R8: enabling an already set bit.
    step('0, 1'b1, 2'd1, 8'h08, 1'b0, 1'b0, "R8");
    idle(2'd1, "R8");
    // R6: the pin holds while pending.
    for (int k = 0; k < 4; k++) idle(2'd0, "R6");
    // R4: set and clear on the same bit in one cycle.
    step(8'h08, 1'b1, 2'd0, 8'h08, 1'b0, 1'b0, "R4");
    idle(2'd0, "R4");
    // R3: partial clear leaves other bits alone.
    step(8'h21, 1'b0, 2'd0, '0, 1'b0, 1'b0, "R3");
    step('0, 1'b1, 2'd0, 8'h09, 1'b0, 1'b0, "R3");
    idle(2'd0, "R6");
    idle(2'd0, "R6");
    // R5: enable and control readback.
    step('0, 1'b1, 2'd1, 8'hA5, 1'b0, 1'b0, "R5");
    step('0, 1'b1, 2'd2, 8'hFF, 1'b0, 1'b0, "R5");
    idle(2'd2, "R5");
    // R9: all hub state combinations in link mode.
    step('0, 1'b0, 2'd2, '0, 1'b1, 1'b0, "R9");
    step('0, 1'b0, 2'd2, '0, 1'b1, 1'b0, "R9");
    step('0, 1'b0, 2'd2, '0, 1'b1, 1'b1, "R9");
    step('0, 1'b0, 2'd2, '0, 1'b0, 1'b0, "R9");
    step('0, 1'b0, 2'd2, '0, 1'b0, 1'b1, "R9");
    step('0, 1'b0, 2'd2, '0, 1'b1, 1'b0, "R9");
    // R10: events in link mode, then back to event mode.
    step('0, 1'b1, 2'd0, 8'hFF, 1'b1, 1'b0, "R10");
    step(8'h04, 1'b0, 2'd0, '0, 1'b1, 1'b0, "R10");
    idle(2'd0, "R10");
    step('0, 1'b1, 2'd2, 8'h00, 1'b1, 1'b0, "R10");
    idle(2'd0, "R10");
    // R11: spare address.
    step('0, 1'b1, 2'd3, 8'h5A, 1'b1, 1'b0, "R11");
    idle(2'd1, "R11");
    idle(2'd2, "R11");

    // Random mix against the bench model.
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] ev;
      logic         we;
      logic [1:0]   a;
      ev = (($urandom % 4) == 0) ? (W'($urandom) & W'($urandom)) : '0;
      we = ($urandom % 3) == 0;
      a  = 2'($urandom);
      step(ev, we, a, W'($urandom), 1'($urandom), 1'($urandom), "R6/R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule